// File: doc/BRIEF.md
# System Counter with Compare Interrupt

This block keeps a free-running 64-bit time base and one compare channel. A prescaler divides the input clock by three, so the counter advances once every three input cycles. Software sees the counter as two 32-bit words and programs a 52-bit compare value as a low word and a 20-bit high word. A control register holds an enable bit, an interrupt mask bit and a read-only status bit.

Once enabled, the channel latches its status as soon as the counter reaches or passes the compare value, and raises the interrupt unless it is masked. The status is sticky. The only way to drop it is to write the enable bit to zero. A driver therefore acknowledges an event by disabling the channel, then reprograms the compare value and enables the channel again. Because the counter keeps running, software reads it high, low, high and retries if the two high reads differ.

Top module: `sysctr_cmp_timer`

## Requirements
- R1: After reset, the counter words, both compare words and the control register all read 0, and `irq` is 0.
- R2: The counter increments by one every DIV (3) input clock cycles, starting at the third rising edge after reset is released. It is read at 0x00008 (bits 31:0) and 0x0000C (bits 63:32).
- R3: The compare low word is at 0x10020 and the compare high word is at 0x10024. Only bits 19:0 of the high word are stored and read back; the others read 0. The comparison uses counter bits 51:0 against {high[19:0], low}.
- R4: While enable is 1 and counter bits 51:0 are at or above the compare value, the status bit is 1 from the next rising edge on, and it stays 1 until enable is cleared. While enable is 0 the status never sets.
- R5: A write to the control register at 0x1002C with bit 0 equal to 0 makes both status and `irq` 0 at the same edge that stores the write.
- R6: `irq` is 1 exactly when status is 1, enable is 1 and the mask is 0. Control bit 0 is enable and bit 1 is the mask.
- R7: Status reads at control bit 2. Writes to bit 2 have no effect.
- R8: Reads from any other offset return 0, and writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; the counter runs at one third of this rate |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe; the write takes effect at this rising edge |
| addr | input | 17 | Byte offset for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Compare interrupt, active high |

## Verification
The bench sweeps compare values from the current count to several ticks beyond it, with the mask both clear and set, and checks status and `irq` on every cycle. A design that compared with `>` instead of `>=`, or that sampled the compare result a cycle late, would fire one tick off. Clearing is tested with the mask held at 1, which catches a design that clears the mask along with the status. The bench also checks that a status bit reached by a write would stay 0, that the upper bits of the compare-high word are truncated and do not block a match, and that unmapped writes leave the mapped registers unchanged.

// File: rtl/sysctr_cmp_timer.sv
module sysctr_cmp_timer #(
  parameter int DIV      = 3,
  parameter int AW       = 17,
  parameter int CMP_HI_W = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          irq
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int CW = 32 + CMP_HI_W;
  localparam logic [AW-1:0] A_CNT_LO = AW'('h00008);
  localparam logic [AW-1:0] A_CNT_HI = AW'('h0000C);
  localparam logic [AW-1:0] A_CMP_LO = AW'('h10020);
  localparam logic [AW-1:0] A_CMP_HI = AW'('h10024);
  localparam logic [AW-1:0] A_CTRL   = AW'('h1002C);

  logic [PW-1:0]       pre;
  logic [63:0]         cnt;
  logic [31:0]         cmp_lo;
  logic [CMP_HI_W-1:0] cmp_hi;
  logic                en, mask, status;

  wire tick   = (pre == PW'(DIV - 1));
  wire wr_ctl = wr_en && (addr == A_CTRL);
  wire clr    = wr_ctl && !wdata[0];
  wire ge     = cnt[CW-1:0] >= {cmp_hi, cmp_lo};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre <= '0;
      cnt <= '0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick) cnt <= cnt + 64'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_lo <= '0;
      cmp_hi <= '0;
      en     <= 1'b0;
      mask   <= 1'b0;
      status <= 1'b0;
    end else begin
      if (wr_en && addr == A_CMP_LO) cmp_lo <= wdata;
      if (wr_en && addr == A_CMP_HI) cmp_hi <= wdata[CMP_HI_W-1:0];
      if (wr_ctl) begin
        en   <= wdata[0];
        mask <= wdata[1];
      end
      if (clr)            status <= 1'b0;
      else if (en && ge)  status <= 1'b1;
    end
  end

  assign irq = status && en && !mask;

  always_comb begin
    case (addr)
      A_CNT_LO: rdata = cnt[31:0];
      A_CNT_HI: rdata = cnt[63:32];
      A_CMP_LO: rdata = cmp_lo;
      A_CMP_HI: rdata = 32'(cmp_hi);
      A_CTRL:   rdata = {29'd0, status, mask, en};
      default:  rdata = 32'd0;
    endcase
  end

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 64'd1));
  p_status_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ge && !clr) |=> status);
  p_status_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !clr) |=> status);
  p_no_set_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !status) |=> !status);
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!status && !irq));
  p_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mask |-> !irq);
endmodule

// File: tb/tb_sysctr_cmp_timer.sv
module tb_sysctr_cmp_timer;
  localparam logic [16:0] CLO = 17'h00008, CHI = 17'h0000C, KLO = 17'h10020,
                          KHI = 17'h10024, CTL = 17'h1002C;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [16:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int total = 0, fails = 0;
  bit done = 0;

  sysctr_cmp_timer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                        .wdata(wdata), .rdata(rdata), .irq(irq));

  always #2 clk = ~clk;

  // reference model built from the requirements
  int unsigned m_pre;
  logic [63:0] m_cnt;
  logic [31:0] m_lo;
  logic [19:0] m_hi;
  logic m_en, m_mask, m_st;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre <= 0; m_cnt <= 0; m_lo <= 0; m_hi <= 0;
      m_en <= 0; m_mask <= 0; m_st <= 0;
    end else begin
      m_pre <= (m_pre == 2) ? 0 : m_pre + 1;
      if (m_pre == 2) m_cnt <= m_cnt + 1;
      if (wr_en && addr == KLO) m_lo <= wdata;
      if (wr_en && addr == KHI) m_hi <= wdata[19:0];
      if (wr_en && addr == CTL) begin m_en <= wdata[0]; m_mask <= wdata[1]; end
      if (wr_en && addr == CTL && !wdata[0]) m_st <= 0;
      else if (m_en && m_cnt[51:0] >= {m_hi, m_lo}) m_st <= 1;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [16:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [16:0] a, output logic [31:0] d);
    wr_en = 0; addr = a; #1; d = rdata;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    logic [63:0] c;
    repeat (4) @(negedge clk);
    // R1: reset state, read while still in reset and just after
    rd(CLO, v); chk("R1", v, 0);
    rd(KLO, v); chk("R1", v, 0);
    rd(KHI, v); chk("R1", v, 0);
    rd(CTL, v); chk("R1", v, 0);
    chk("R1", irq, 0);
    rst_n = 1;
    @(negedge clk);
    rd(CHI, v); chk("R1", v, 0);

    // R2: counter follows clock/3 on every cycle
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      rd(CLO, v); chk("R2 low word", v, m_cnt[31:0]);
      rd(CHI, v); chk("R2 high word", v, m_cnt[63:32]);
    end
    chk("R2 rate", m_cnt, 64'd10);

    // R3: compare-high truncation
    wr(KHI, 32'hFFFF_FFFF);
    rd(KHI, v); chk("R3 readback", v, 32'h000F_FFFF);
    wr(KHI, 32'hFFF0_0000);
    rd(KHI, v); chk("R3 upper ignored", v, 0);
    wr(KLO, 32'd0);
    wr(CTL, 32'd1);
    @(negedge clk);
    rd(CTL, v); chk("R3 match despite upper bits", v, 32'd5);
    wr(CTL, 32'd0);

    // R4/R6: sweep compare offsets with mask clear and set
    for (int mk = 0; mk < 2; mk++) begin
      for (int d = 0; d < 7; d++) begin
        wr(CTL, 32'(mk << 1));
        c = m_cnt + 64'(d);
        wr(KHI, 32'(c[51:32]));
        wr(KLO, c[31:0]);
        wr(CTL, 32'(1 | (mk << 1)));
        for (int k = 0; k < 25; k++) begin
          @(negedge clk);
          rd(CTL, v); chk("R4 status", v, {29'd0, m_st, m_mask, m_en});
          chk("R6 irq", irq, m_st & m_en & ~m_mask);
        end
        chk("R4 fired", m_st, 1);
      end
    end

    // R6: unmask a pending status
    wr(CTL, 32'd1);
    @(negedge clk); chk("R6 unmasked", irq, 1);

    // R5: clear keeps mask, drops status and irq at the same edge
    wr(CTL, 32'd3);
    @(negedge clk); chk("R6 masked pending", irq, 0);
    @(negedge clk); wr_en = 1; addr = CTL; wdata = 32'd2;
    @(negedge clk); wr_en = 0;
    chk("R5 irq", irq, 0);
    rd(CTL, v); chk("R5 ctrl", v, 32'd2);
    wr(CTL, 32'd1);
    @(negedge clk); chk("R5 re-enable", irq, 1);
    @(negedge clk); wr_en = 1; addr = CTL; wdata = 32'd0;
    @(negedge clk); wr_en = 0;
    chk("R5 irq unmasked clear", irq, 0);

    // R7: bit 2 not writable, and no set while disabled
    wr(CTL, 32'd4);
    repeat (6) @(negedge clk);
    rd(CTL, v); chk("R7 status write ignored", v, 0);
    chk("R7 irq", irq, 0);
    c = m_cnt + 64'd1000;
    wr(KHI, 32'(c[51:32])); wr(KLO, c[31:0]);
    wr(CTL, 32'd5);
    repeat (3) @(negedge clk);
    rd(CTL, v); chk("R7 status stays clear", v, 32'd1);
    wr(CTL, 32'd0);

    // R8: unmapped offsets
    rd(17'h00000, v); chk("R8 read 0x0", v, 0);
    rd(17'h10028, v); chk("R8 read 0x10028", v, 0);
    rd(17'h00020, v); chk("R8 read alias", v, 0);
    wr(17'h00020, 32'hDEAD_BEEF);
    wr(17'h0002C, 32'd3);
    wr(17'h10028, 32'hFFFF_FFFF);
    rd(KLO, v); chk("R8 cmp low kept", v, c[31:0]);
    rd(KHI, v); chk("R8 cmp high kept", v, 32'(c[51:32]));
    rd(CTL, v); chk("R8 ctrl kept", v, 0);
    rd(CLO, v); chk("R8 counter kept", v, m_cnt[31:0]);

    done = 1;
    summary();
  end
endmodule